// File: doc/BRIEF.md
# Regulator Channel Supervisor

This block oversees one channel of a switching regulator. Comparator flags arrive from the analog side and are used here as digital inputs. They report the supply lockout levels, over-voltage at 120 %, under-voltage at 75 %, an output inside the ±10 % window, and the two die-temperature levels. Each flag is debounced by a consecutive-sample filter. The block then sequences startup and generates a digital soft-start ramp code that feeds the reference clamp. It also produces the run, power-good, forced-PWM, forced-low-side and latched-fault controls.

Over-voltage acts as a soft crowbar that does not latch: the low-side switch is held on only while the filtered flag is high. Under-voltage has no effect until the ramp has reached the regulation code. Once armed, it shuts the channel off and latches the fault. Two things clear the latch: taking enable low and back high, or a supply power-on reset. The ramp keeps climbing to a second, higher code. When it gets there, power-good is allowed and the forced-PWM request is released.

Top module: `reg_supervisor`

## Requirements
- R1: Supply qualification uses hysteresis. The channel may start only after the filtered rising-level flag has been high. It keeps running while the filtered holding-level flag stays high, even if the rising-level flag then drops. When the holding-level flag goes low, the channel stops and any latched fault is cleared.
- R2: A raw flag reaches the control logic only after it has held a new value for FILT_LEN consecutive clocks. A pulse of FILT_LEN-1 clocks has no effect on any output.
- R3: While the channel runs, `ss_code_o` starts at 0 and rises by one every STEP_DIV clocks until it saturates at PG_CODE. It returns to 0 whenever the channel is not running.
- R4: `force_pwm_o` is high while the channel runs and the ramp is below PG_CODE. It is low otherwise.
- R5: `pgood_o` is high only when all three of these hold: the ramp has reached PG_CODE, the filtered in-window flag is high, and no fault is latched.
- R6: While the channel runs, a filtered over-voltage flag drives `force_ls_o` high. The output drops again as soon as the flag clears. No fault is latched.
- R7: An under-voltage flag is ignored while the ramp is below REF_CODE. From REF_CODE upward it sets `fault_o`, drops `run_o` and resets the ramp.
- R8: A latched fault persists after the under-voltage flag clears. Taking enable low clears it, and enable high starts a new ramp.
- R9: The over-temperature flag shuts the channel down. A restart waits for the cool flag and then begins with a full ramp from 0.
- R10: Enable low stops the channel and resets the ramp. After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Channel enable |
| vcc_rise_i | input | 1 | Supply above the start level |
| vcc_hold_i | input | 1 | Supply above the stop level |
| ov_i | input | 1 | Output above 120 % of the set point |
| uv_i | input | 1 | Output below 75 % of the set point |
| win_i | input | 1 | Output within ±10 % of the set point |
| ot_hot_i | input | 1 | Die above the shutdown temperature |
| ot_cool_i | input | 1 | Die below the restart temperature |
| ss_code_o | output | SS_W | Soft-start ramp code |
| run_o | output | 1 | Channel running |
| pgood_o | output | 1 | Power good |
| force_ls_o | output | 1 | Force low-side switch on |
| force_pwm_o | output | 1 | Force PWM mode (no light-load mode) |
| fault_o | output | 1 | Latched fault |

## Verification
The flag filter gets two over-voltage pulses, one a single clock shorter than the filter length and one exactly as long. The pair separates an off-by-one in the debounce count from correct behaviour. Under-voltage is applied twice: once early in the ramp and held clear of REF_CODE, and once after the ramp has finished. This shows whether the arming threshold is honoured. The fault latch is cleared in two ways, through an enable toggle and through a supply drop, and the hysteresis test drops the two supply flags one at a time. Over-temperature is released in two stages so that a missing cool-flag wait becomes visible.

// File: rtl/reg_supervisor_pkg.sv
package reg_supervisor_pkg;
  typedef enum logic [1:0] {SV_OFF, SV_RAMP, SV_RUN, SV_FAULT} sv_state_e;

  localparam int FL_EN   = 0;
  localparam int FL_RISE = 1;
  localparam int FL_HOLD = 2;
  localparam int FL_OV   = 3;
  localparam int FL_UV   = 4;
  localparam int FL_WIN  = 5;
  localparam int FL_HOT  = 6;
  localparam int FL_COOL = 7;
  localparam int NUM_FL  = 8;
endpackage

// File: rtl/flag_filter.sv
module flag_filter #(
  parameter int LEN = 400
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic filt_o
);
  localparam int CW = $clog2(LEN + 1);

  logic [CW-1:0] cnt_q;
  logic          filt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      filt_q <= 1'b0;
    end else if (raw_i == filt_q) begin
      cnt_q <= '0;
    end else if (cnt_q == CW'(LEN - 1)) begin
      cnt_q  <= '0;
      filt_q <= raw_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign filt_o = filt_q;

  // R2: the filtered value only moves after a full run of disagreeing samples
  a_r2_filt_needs_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (filt_q != $past(filt_q)) |-> ($past(cnt_q) == CW'(LEN - 1) && $past(raw_i) == filt_q));
endmodule

// File: rtl/ss_ramp.sv
module ss_ramp #(
  parameter int SS_W     = 8,
  parameter int STEP_DIV = 64,
  parameter int TOP_CODE = 150
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  output logic [SS_W-1:0] code_o
);
  localparam int DW = $clog2(STEP_DIV + 1);

  logic [DW-1:0]   div_q;
  logic [SS_W-1:0] code_q;
  logic            at_top;

  assign at_top = (code_q == SS_W'(TOP_CODE));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      code_q <= '0;
    end else if (!run_i) begin
      div_q  <= '0;
      code_q <= '0;
    end else if (div_q == DW'(STEP_DIV - 1)) begin
      div_q <= '0;
      if (!at_top) code_q <= code_q + 1'b1;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  assign code_o = code_q;

  a_r3_step_by_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(run_i) |-> (code_q == $past(code_q) || code_q == $past(code_q) + 1'b1));
  a_r3_zero_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (code_q == '0));
  a_r3_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_q <= SS_W'(TOP_CODE));
endmodule

// File: rtl/reg_supervisor.sv
module reg_supervisor
  import reg_supervisor_pkg::*;
#(
  parameter int FILT_LEN = 400,
  parameter int STEP_DIV = 64,
  parameter int SS_W     = 8,
  parameter int REF_CODE = 90,
  parameter int PG_CODE  = 150
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            vcc_rise_i,
  input  logic            vcc_hold_i,
  input  logic            ov_i,
  input  logic            uv_i,
  input  logic            win_i,
  input  logic            ot_hot_i,
  input  logic            ot_cool_i,
  output logic [SS_W-1:0] ss_code_o,
  output logic            run_o,
  output logic            pgood_o,
  output logic            force_ls_o,
  output logic            force_pwm_o,
  output logic            fault_o
);
  logic [NUM_FL-1:0] raw, flt;
  sv_state_e         state_q, state_d;
  logic              sup_ok_q, ot_lock_q;
  logic              running, uv_armed, ramp_top;
  logic [SS_W-1:0]   ss_code;

  assign raw[FL_EN]   = en_i;
  assign raw[FL_RISE] = vcc_rise_i;
  assign raw[FL_HOLD] = vcc_hold_i;
  assign raw[FL_OV]   = ov_i;
  assign raw[FL_UV]   = uv_i;
  assign raw[FL_WIN]  = win_i;
  assign raw[FL_HOT]  = ot_hot_i;
  assign raw[FL_COOL] = ot_cool_i;

  for (genvar g = 0; g < NUM_FL; g++) begin : g_filt
    flag_filter #(.LEN(FILT_LEN)) u_filt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .raw_i  (raw[g]),
      .filt_o (flt[g])
    );
  end

  // supply hysteresis and thermal lock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sup_ok_q  <= 1'b0;
      ot_lock_q <= 1'b0;
    end else begin
      sup_ok_q  <= flt[FL_HOLD] && (flt[FL_RISE] || sup_ok_q);
      if (flt[FL_HOT])       ot_lock_q <= 1'b1;
      else if (flt[FL_COOL]) ot_lock_q <= 1'b0;
    end
  end

  assign running  = (state_q == SV_RAMP) || (state_q == SV_RUN);
  assign uv_armed = (ss_code >= SS_W'(REF_CODE));
  assign ramp_top = (ss_code == SS_W'(PG_CODE));

  always_comb begin
    state_d = state_q;
    if (!sup_ok_q) begin
      state_d = SV_OFF;
    end else begin
      unique case (state_q)
        SV_OFF:   if (flt[FL_EN] && !ot_lock_q) state_d = SV_RAMP;
        SV_RAMP, SV_RUN: begin
          if (!flt[FL_EN] || ot_lock_q)      state_d = SV_OFF;
          else if (uv_armed && flt[FL_UV])   state_d = SV_FAULT;
          else if (ramp_top)                 state_d = SV_RUN;
        end
        SV_FAULT: if (!flt[FL_EN])           state_d = SV_OFF;
        default:                             state_d = SV_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SV_OFF;
    else         state_q <= state_d;
  end

  ss_ramp #(.SS_W(SS_W), .STEP_DIV(STEP_DIV), .TOP_CODE(PG_CODE)) u_ramp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (running),
    .code_o (ss_code)
  );

  assign ss_code_o   = ss_code;
  assign run_o       = running;
  assign fault_o     = (state_q == SV_FAULT);
  assign force_pwm_o = running && !ramp_top;
  assign force_ls_o  = running && flt[FL_OV];
  assign pgood_o     = (state_q == SV_RUN) && ramp_top && flt[FL_WIN];

  a_r5_pg_qualified: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pgood_o |-> (run_o && !fault_o && !force_pwm_o));
  a_r7_fault_stops_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> !run_o);
  a_r7_uv_needs_arming: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_o) |-> ($past(ss_code) >= SS_W'(REF_CODE)));
  a_r6_ls_only_running: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_ls_o |-> run_o);
  a_r8_fault_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(fault_o) && $past(flt[FL_EN]) && $past(sup_ok_q)) |-> fault_o);
  a_r1_off_without_supply: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(sup_ok_q) |-> (!run_o && !fault_o));
endmodule

// File: tb/reg_supervisor_tb.sv
module reg_supervisor_tb_top;
  localparam int FL = 4;
  localparam int SD = 4;
  localparam int SW = 5;
  localparam int RC = 6;
  localparam int PC = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en, rise, hold, ov, uv, win, hot, cool;
  logic [SW-1:0] ss;
  logic run, pg, fls, fpwm, flt;
  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  reg_supervisor #(.FILT_LEN(FL), .STEP_DIV(SD), .SS_W(SW), .REF_CODE(RC), .PG_CODE(PC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .vcc_rise_i(rise), .vcc_hold_i(hold),
    .ov_i(ov), .uv_i(uv), .win_i(win), .ot_hot_i(hot), .ot_cool_i(cool),
    .ss_code_o(ss), .run_o(run), .pgood_o(pg), .force_ls_o(fls),
    .force_pwm_o(fpwm), .fault_o(flt)
  );

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=%0d expected<=100000", cyc);
      summary();
    end
  end

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_full_ramp(string req);
    int n = 0;
    while (!(run && !fpwm) && n < 300) begin step(); n++; end
    chk({req, " ramp reaches top"}, int'(ss), PC);
  endtask

  task automatic t_reset();
    chk("R10 reset run", run, 0);
    chk("R10 reset pg", pg, 0);
    chk("R10 reset fault", flt, 0);
    chk("R10 reset ss", int'(ss), 0);
    chk("R10 reset ls", fls, 0);
  endtask

  task automatic t_hysteresis();
    step(20);
    chk("R1 no start without rise flag", run, 0);
    rise = 1'b1;
    wait_full_ramp("R1");
    rise = 1'b0;
    step(10);
    chk("R1 keeps running on hold flag", run, 1);
    hold = 1'b0;
    step(8);
    chk("R1 stops on hold loss", run, 0);
    chk("R3 ramp cleared after stop", int'(ss), 0);
    rise = 1'b1; hold = 1'b1;
  endtask

  task automatic t_ramp();
    int n = 0;
    while (ss != 2 && n < 200) begin step(); n++; end
    chk("R4 force pwm during ramp", fpwm, 1);
    chk("R5 no pg during ramp", pg, 0);
    n = 0;
    while (ss == 2 && n < 50) begin step(); n++; end
    chk("R3 step interval", n, SD);
    chk("R3 next code", int'(ss), 3);
    wait_full_ramp("R3");
    step(3 * SD);
    chk("R3 saturated", int'(ss), PC);
    chk("R4 pwm released at top", fpwm, 0);
    chk("R5 pg at top in window", pg, 1);
  endtask

  task automatic t_window();
    win = 1'b0;
    step(6);
    chk("R5 pg low outside window", pg, 0);
    chk("R5 still running", run, 1);
    win = 1'b1;
    step(6);
    chk("R5 pg back in window", pg, 1);
  endtask

  task automatic t_ov();
    ov = 1'b1;
    for (int i = 0; i < FL - 1; i++) begin
      step();
      chk("R2 short ov pulse ignored", fls, 0);
    end
    ov = 1'b0;
    step(6);
    chk("R2 short ov pulse ignored after", fls, 0);
    ov = 1'b1;
    step(FL - 1);
    chk("R2 ov not yet through filter", fls, 0);
    step();
    chk("R6 ov forces low side", fls, 1);
    ov = 1'b0;
    step(FL);
    chk("R6 ov released", fls, 0);
    chk("R6 no latch", flt, 0);
    chk("R6 still running", run, 1);
  endtask

  task automatic t_uv_and_clear();
    int n = 0;
    en = 1'b0;
    step(8);
    chk("R10 enable low stops", run, 0);
    chk("R10 enable low clears ramp", int'(ss), 0);
    en = 1'b1;
    while (ss != 1 && n < 200) begin step(); n++; end
    uv = 1'b1;
    step(8);
    uv = 1'b0;
    step(6);
    chk("R7 uv ignored before arming", flt, 0);
    chk("R7 still running early uv", run, 1);
    wait_full_ramp("R7");
    uv = 1'b1;
    step(8);
    chk("R7 uv latches fault", flt, 1);
    chk("R7 uv stops run", run, 0);
    chk("R7 ramp cleared", int'(ss), 0);
    chk("R5 no pg in fault", pg, 0);
    uv = 1'b0;
    step(10);
    chk("R8 fault persists", flt, 1);
    en = 1'b0;
    step(8);
    chk("R8 enable low clears fault", flt, 0);
    en = 1'b1;
    wait_full_ramp("R8");
    uv = 1'b1;
    step(8);
    uv = 1'b0;
    chk("R8 fault again", flt, 1);
    hold = 1'b0; rise = 1'b0;
    step(8);
    chk("R8 power-on reset clears fault", flt, 0);
    hold = 1'b1; rise = 1'b1;
    wait_full_ramp("R8 restart");
  endtask

  task automatic t_ot();
    hot = 1'b1;
    step(8);
    chk("R9 hot shuts down", run, 0);
    hot = 1'b0;
    step(10);
    chk("R9 waits for cool flag", run, 0);
    cool = 1'b1;
    step(8);
    chk("R9 restarts after cool", run, 1);
    chk("R9 full soft start", fpwm, 1);
    chk("R9 ramp from low code", int'(ss < 2), 1);
    cool = 1'b0;
    wait_full_ramp("R9");
  endtask

  initial begin
    en = 1'b1; rise = 1'b0; hold = 1'b1; ov = 1'b0; uv = 1'b0;
    win = 1'b1; hot = 1'b0; cool = 1'b0;
    step(3);
    t_reset();
    rst_n = 1'b1;
    step();
    t_hysteresis();
    t_ramp();
    t_window();
    t_ov();
    t_uv_and_clear();
    t_ot();
    summary();
  end
endmodule